// File: doc/BRIEF.md
# Three-state snooping coherence controller for a direct-mapped cache

This block holds the coherence state, tag and one data word for every line of a small direct-mapped cache that sits on a shared snooping bus. Each line is Invalid, Shared (read-only, possibly also held elsewhere) or Modified (read-write, the only valid copy). A processor request is served locally when the line state allows it. Otherwise the block asks the bus arbiter for the bus and issues a read or a read-exclusive. It then waits for memory to signal ready with the fill word.

The block also watches every transaction other caches put on the bus. It downgrades or invalidates its copy as needed and drives the line's data on a flush port when it held the line Modified. There is no upgrade transaction, so a write to a Shared line issues a full read-exclusive. If a miss would evict a Modified line of another tag, the old line is written back through the flush port first. The bus is assumed to deliver every transaction to all caches in one global order.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `pr_ready` is 1 and `bq_req`, `pr_done` and `fl_valid` are 0.
- R2: A read to an Invalid line requests the bus with command read (code 1) at the request address. After grant and `bus_ready` the line becomes Shared and `pr_rdata` returns `bus_rdata`. The line index is the low `IDX_W` address bits and the tag is the rest.
- R3: A read that hits a Shared or Modified line completes without a bus request, returns the stored word and leaves the state unchanged.
- R4: A write to an Invalid line, or to a Shared line of the same tag, issues a read-exclusive (code 2), then stores the write word and makes the line Modified.
- R5: A write that hits a Modified line completes without a bus request and replaces the stored word.
- R6: A snooped read (code 1) from another cache that hits a Modified line raises `fl_valid` for one cycle with that line's address and word, and leaves the line Shared.
- R7: A snooped read that hits a Shared line does nothing. A snooped read-exclusive that hits a Shared line makes it Invalid without a flush.
- R8: A snooped read-exclusive (code 2) that hits a Modified line flushes the line's address and word and makes it Invalid.
- R9: A snoop whose source ID equals `MY_ID`, or whose tag differs from the resident line's tag, changes neither the state nor the flush port.
- R10: While a request waits for grant, a snoop to the same line is applied first, and the bus command shown is recomputed from the updated state in the following cycle.
- R11: A miss that would replace a Modified line of another tag first issues a write-back (code 3) at the old line's address. On its grant the old word appears on the flush port, and then the new read or read-exclusive is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pr_valid | input | 1 | Processor request, accepted when `pr_ready` is 1 |
| pr_write | input | 1 | 1 = write, 0 = read |
| pr_addr | input | ADDR_W | Word address of the request |
| pr_wdata | input | DATA_W | Write word |
| pr_ready | output | 1 | Controller idle, can accept a request |
| pr_done | output | 1 | One-cycle completion pulse |
| pr_rdata | output | DATA_W | Read word (the write word for writes), valid with `pr_done` |
| bq_req | output | 1 | Bus request, held until granted |
| bq_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 write-back |
| bq_addr | output | ADDR_W | Address of the requested transaction |
| bq_gnt | input | 1 | Bus grant; the transaction is on the bus in this cycle |
| bus_ready | input | 1 | Memory has the fill word for the granted read |
| bus_rdata | input | DATA_W | Fill word |
| sn_valid | input | 1 | A bus transaction is visible to snoopers |
| sn_cmd | input | 2 | Snooped command, same codes as `bq_cmd` |
| sn_addr | input | ADDR_W | Snooped address |
| sn_src | input | SRC_W | ID of the cache that issued the snooped transaction |
| fl_valid | output | 1 | Flush word valid (one cycle) |
| fl_addr | output | ADDR_W | Address of the flushed line |
| fl_data | output | DATA_W | Flushed word |

## Verification
A request is taken at the edge where `pr_valid` meets `pr_ready`. A hit raises `pr_done` one edge later. On a miss, `bq_req` is visible in the cycle after acceptance. The fill follows at the edge that samples `bus_ready`, one edge after the grant, and `pr_done` shows up in the next cycle. A snoop flush and a write-back flush each appear one edge after the snoop or the grant that caused them. The bench drives and samples on falling edges and serves the bus one cycle at a time, so it records the exact sequence of bus commands, flushes and completion for each scenario. Line state is observed through the ports only, by whether a later read or write needs the bus.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_SHR = 2'd1, LN_MOD = 2'd2} line_st_e;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_WB = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_PEND = 2'd1, F_FILL = 2'd2} fsm_e;
endpackage

// File: rtl/msi_snoop_eval.sv
module msi_snoop_eval
  import msi_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int SRC_W = 2,
  parameter int MY_ID = 1
) (
  input  logic             sn_valid,
  input  logic [1:0]       sn_cmd,
  input  logic [TAG_W-1:0] sn_tag,
  input  logic [SRC_W-1:0] sn_src,
  input  line_st_e         cur_st,
  input  logic [TAG_W-1:0] cur_tag,
  output logic             hit,
  output line_st_e         new_st,
  output logic             flush
);
  logic foreign;

  always_comb begin
    foreign = sn_valid && (sn_src != SRC_W'(MY_ID));
    hit     = foreign && (cur_st != LN_INV) && (cur_tag == sn_tag) &&
              ((sn_cmd == BC_RD) || (sn_cmd == BC_RDX));
    new_st  = cur_st;
    flush   = 1'b0;
    if (hit) begin
      flush  = (cur_st == LN_MOD);
      new_st = (sn_cmd == BC_RDX) ? LN_INV : LN_SHR;
    end
  end
endmodule

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              sn_we,
  input  line_st_e          sn_wst,
  input  logic              own_we,
  input  line_st_e          own_st,
  input  logic              own_load,
  input  logic [TAG_W-1:0]  own_tag,
  input  logic [DATA_W-1:0] own_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q  [LINES];
  line_st_e          st_d  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] data_q[LINES];

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

  // owner port wins over the snoop port on the same index
  always_comb begin
    for (int i = 0; i < LINES; i++) st_d[i] = st_q[i];
    if (sn_we) st_d[b_idx] = sn_wst;
    if (own_we) st_d[a_idx] = own_st;
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic ld_en;
      assign ld_en = own_we && own_load && (a_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[g]  <= LN_INV;
          tag_q[g] <= '0;
        end else begin
          st_q[g] <= st_d[g];
          if (ld_en) tag_q[g] <= own_tag;
        end
      end

      always_ff @(posedge clk) begin
        if (ld_en) data_q[g] <= own_data;
      end
    end
  endgenerate
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pr_valid,
  input  logic              pr_write,
  input  logic [ADDR_W-1:0] pr_addr,
  input  logic [DATA_W-1:0] pr_wdata,
  output logic              pr_ready,
  output logic              pr_done,
  output logic [DATA_W-1:0] pr_rdata,
  output logic [IDX_W-1:0]  pend_idx,
  input  line_st_e          eff_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              bq_req,
  output logic [1:0]        bq_cmd,
  output logic [ADDR_W-1:0] bq_addr,
  input  logic              bq_gnt,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              own_we,
  output line_st_e          own_st,
  output logic              own_load,
  output logic [TAG_W-1:0]  own_tag,
  output logic [DATA_W-1:0] own_data,
  output logic              wb_fire
);
  fsm_e              st_q, st_d;
  logic              pend_wr;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;
  logic              cap_en, done_d;
  logic [DATA_W-1:0] rdata_d;
  logic [TAG_W-1:0]  pend_tag;
  logic              tag_eq, local_ok, need_wb;
  bus_cmd_e          cmd;

  assign pend_idx = pend_addr[IDX_W-1:0];
  assign pend_tag = pend_addr[ADDR_W-1:IDX_W];

  // action is recomputed every cycle from the snoop-adjusted state
  always_comb begin
    tag_eq   = (ln_tag == pend_tag);
    local_ok = pend_wr ? (tag_eq && eff_st == LN_MOD) : (tag_eq && eff_st != LN_INV);
    need_wb  = !tag_eq && (eff_st == LN_MOD);
    cmd      = need_wb ? BC_WB : (pend_wr ? BC_RDX : BC_RD);
  end

  always_comb begin
    st_d     = st_q;
    pr_ready = 1'b0;
    cap_en   = 1'b0;
    done_d   = 1'b0;
    rdata_d  = pr_rdata;
    bq_req   = 1'b0;
    own_we   = 1'b0;
    own_st   = LN_INV;
    own_load = 1'b0;
    own_tag  = pend_tag;
    own_data = pend_wdata;
    wb_fire  = 1'b0;
    case (st_q)
      F_IDLE: begin
        pr_ready = 1'b1;
        if (pr_valid) begin
          cap_en = 1'b1;
          st_d   = F_PEND;
        end
      end
      F_PEND: begin
        if (local_ok) begin
          done_d  = 1'b1;
          st_d    = F_IDLE;
          rdata_d = pend_wr ? pend_wdata : ln_data;
          if (pend_wr) begin
            own_we   = 1'b1;
            own_st   = LN_MOD;
            own_load = 1'b1;
          end
        end else begin
          bq_req = 1'b1;
          if (bq_gnt) begin
            if (need_wb) begin
              wb_fire = 1'b1;
              own_we  = 1'b1;
              own_st  = LN_INV;
            end else begin
              st_d = F_FILL;
            end
          end
        end
      end
      F_FILL: begin
        if (bus_ready) begin
          own_we   = 1'b1;
          own_load = 1'b1;
          own_st   = pend_wr ? LN_MOD : LN_SHR;
          own_data = pend_wr ? pend_wdata : bus_rdata;
          rdata_d  = own_data;
          done_d   = 1'b1;
          st_d     = F_IDLE;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  assign bq_cmd  = bq_req ? cmd : BC_NONE;
  assign bq_addr = need_wb ? {ln_tag, pend_idx} : pend_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      pr_done <= 1'b0;
    end else begin
      st_q    <= st_d;
      pr_done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wr    <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
      pr_rdata   <= '0;
    end else begin
      if (cap_en) begin
        pend_wr    <= pr_write;
        pend_addr  <= pr_addr;
        pend_wdata <= pr_wdata;
      end
      if (done_d) pr_rdata <= rdata_d;
    end
  end

  // R10: once raised, a bus request stays up until granted
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bq_req && !bq_gnt) |=> bq_req);

  // R3: completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pr_done |=> !pr_done);
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pr_valid,
  input  logic              pr_write,
  input  logic [ADDR_W-1:0] pr_addr,
  input  logic [DATA_W-1:0] pr_wdata,
  output logic              pr_ready,
  output logic              pr_done,
  output logic [DATA_W-1:0] pr_rdata,
  output logic              bq_req,
  output logic [1:0]        bq_cmd,
  output logic [ADDR_W-1:0] bq_addr,
  input  logic              bq_gnt,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              sn_valid,
  input  logic [1:0]        sn_cmd,
  input  logic [ADDR_W-1:0] sn_addr,
  input  logic [SRC_W-1:0]  sn_src,
  output logic              fl_valid,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  pend_idx, sn_idx;
  logic [TAG_W-1:0]  sn_tag, a_tag, b_tag, own_tag;
  logic [DATA_W-1:0] a_data, b_data, own_data;
  line_st_e          a_st, b_st, sn_new, own_st, eff_st;
  logic              sn_hit, sn_flush, own_we, own_load, wb_fire;

  assign sn_idx = sn_addr[IDX_W-1:0];
  assign sn_tag = sn_addr[ADDR_W-1:IDX_W];

  msi_snoop_eval #(.TAG_W(TAG_W), .SRC_W(SRC_W), .MY_ID(MY_ID)) u_snoop (
    .sn_valid(sn_valid), .sn_cmd(sn_cmd), .sn_tag(sn_tag), .sn_src(sn_src),
    .cur_st(b_st), .cur_tag(b_tag), .hit(sn_hit), .new_st(sn_new), .flush(sn_flush)
  );

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(pend_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(sn_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .sn_we(sn_hit), .sn_wst(sn_new),
    .own_we(own_we), .own_st(own_st), .own_load(own_load),
    .own_tag(own_tag), .own_data(own_data)
  );

  // a snoop in this cycle is ordered ahead of the pending request
  assign eff_st = (sn_hit && sn_idx == pend_idx) ? sn_new : a_st;

  msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pr_valid(pr_valid), .pr_write(pr_write), .pr_addr(pr_addr), .pr_wdata(pr_wdata),
    .pr_ready(pr_ready), .pr_done(pr_done), .pr_rdata(pr_rdata), .pend_idx(pend_idx),
    .eff_st(eff_st), .ln_tag(a_tag), .ln_data(a_data),
    .bq_req(bq_req), .bq_cmd(bq_cmd), .bq_addr(bq_addr), .bq_gnt(bq_gnt),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .own_we(own_we), .own_st(own_st), .own_load(own_load),
    .own_tag(own_tag), .own_data(own_data), .wb_fire(wb_fire)
  );

  // snoop flush takes the port; a write-back only runs while this cache owns the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_valid <= 1'b0;
      fl_addr  <= '0;
      fl_data  <= '0;
    end else begin
      fl_valid <= sn_flush || wb_fire;
      if (sn_flush) begin
        fl_addr <= sn_addr;
        fl_data <= b_data;
      end else if (wb_fire) begin
        fl_addr <= {a_tag, pend_idx};
        fl_data <= a_data;
      end
    end
  end

  // R6 / R8: a foreign snoop that finds the line Modified produces a flush next cycle
  assert_snoop_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_valid && sn_src != SRC_W'(MY_ID) && b_st == LN_MOD && b_tag == sn_tag &&
     (sn_cmd == BC_RD || sn_cmd == BC_RDX)) |=> (fl_valid && fl_addr == $past(sn_addr)));

  // R9: own transactions seen on the snoop input never cause a flush
  assert_own_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_valid && sn_src == SRC_W'(MY_ID) && !(bq_req && bq_gnt)) |=> !fl_valid);

  // R11: a granted write-back puts the old line on the flush port
  assert_wb_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bq_req && bq_gnt && bq_cmd == BC_WB && !sn_valid) |=> (fl_valid && fl_addr == $past(bq_addr)));
endmodule

// File: tb/msi_line_ctrl_bench.sv
module msi_line_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int ME = 1;
  localparam int OTHER = 2;
  localparam logic [1:0] C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic pr_valid, pr_write, pr_ready, pr_done;
  logic [AW-1:0] pr_addr, bq_addr, sn_addr, fl_addr;
  logic [DW-1:0] pr_wdata, pr_rdata, bus_rdata, fl_data;
  logic bq_req, bq_gnt, bus_ready, sn_valid, fl_valid;
  logic [1:0] bq_cmd, sn_cmd, sn_src;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // results of the last processor request
  int n_cmd, n_fl;
  logic [1:0] cmds [4];
  logic [AW-1:0] caddr [4];
  logic [AW-1:0] last_fl_addr;
  logic [DW-1:0] last_fl_data, last_rdata;
  bit got_done;

  always #10 clk = ~clk;

  msi_line_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW), .SRC_W(2), .MY_ID(ME)) u_msi_line_ctrl (
    .clk(clk), .rst_n(rst_n), .pr_valid(pr_valid), .pr_write(pr_write), .pr_addr(pr_addr),
    .pr_wdata(pr_wdata), .pr_ready(pr_ready), .pr_done(pr_done), .pr_rdata(pr_rdata),
    .bq_req(bq_req), .bq_cmd(bq_cmd), .bq_addr(bq_addr), .bq_gnt(bq_gnt),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .sn_valid(sn_valid), .sn_cmd(sn_cmd),
    .sn_addr(sn_addr), .sn_src(sn_src), .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_data(fl_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // serve the bus for one processor request; sampling on falling edges
  task automatic run_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [DW-1:0] fill);
    bit fill_due = 0;
    n_cmd = 0; n_fl = 0; got_done = 0;
    @(negedge clk);
    pr_valid = 1'b1; pr_write = wr; pr_addr = a; pr_wdata = wd;
    @(negedge clk);
    pr_valid = 1'b0;
    for (int c = 0; c < 30 && !got_done; c++) begin
      bq_gnt = 1'b0; bus_ready = 1'b0;
      if (fl_valid) begin n_fl++; last_fl_addr = fl_addr; last_fl_data = fl_data; end
      if (pr_done) begin
        got_done = 1; last_rdata = pr_rdata;
      end else if (fill_due) begin
        bus_ready = 1'b1; bus_rdata = fill; fill_due = 0;
      end else if (bq_req) begin
        if (n_cmd < 4) begin cmds[n_cmd] = bq_cmd; caddr[n_cmd] = bq_addr; end
        n_cmd++;
        bq_gnt = 1'b1;
        fill_due = (bq_cmd != C_WB);
      end
      if (!got_done) @(negedge clk);
    end
    bq_gnt = 1'b0; bus_ready = 1'b0;
  endtask

  // one snoop cycle; returns whether a flush followed, with its address and word
  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [1:0] src,
                       output bit fv, output logic [AW-1:0] fa, output logic [DW-1:0] fd);
    @(negedge clk);
    sn_valid = 1'b1; sn_cmd = cmd; sn_addr = a; sn_src = src;
    @(negedge clk);
    sn_valid = 1'b0;
    fv = fl_valid; fa = fl_addr; fd = fl_data;
  endtask

  task automatic t_reset;
    chk("R1 pr_ready", pr_ready, 1);
    chk("R1 bq_req", bq_req, 0);
    chk("R1 fl_valid", fl_valid, 0);
    chk("R1 pr_done", pr_done, 0);
    run_req(0, 8'h04, 0, 16'h0404);
    chk("R1 cold read needs bus", n_cmd, 1);
  endtask

  task automatic t_read_miss;
    run_req(0, 8'h10, 0, 16'hA5A5);
    chk("R2 one command", n_cmd, 1);
    chk("R2 command is read", cmds[0], C_RD);
    chk("R2 address", caddr[0], 8'h10);
    chk("R2 data", last_rdata, 16'hA5A5);
    run_req(0, 8'h10, 0, 16'hFFFF);
    chk("R3 shared read hit no bus", n_cmd, 0);
    chk("R3 shared read data", last_rdata, 16'hA5A5);
  endtask

  task automatic t_write_upgrade;
    run_req(1, 8'h10, 16'h1111, 16'h0);
    chk("R4 shared write count", n_cmd, 1);
    chk("R4 shared write readx", cmds[0], C_RDX);
    run_req(1, 8'h21, 16'h2222, 16'h0);
    chk("R4 invalid write readx", cmds[0], C_RDX);
    chk("R4 invalid write count", n_cmd, 1);
  endtask

  task automatic t_write_hit;
    run_req(1, 8'h10, 16'h3333, 16'h0);
    chk("R5 modified write no bus", n_cmd, 0);
    run_req(0, 8'h10, 0, 16'h0);
    chk("R3 modified read no bus", n_cmd, 0);
    chk("R5 stored word", last_rdata, 16'h3333);
  endtask

  task automatic t_snoop_rd_mod;
    bit fv; logic [AW-1:0] fa; logic [DW-1:0] fd;
    snoop(C_RD, 8'h10, OTHER, fv, fa, fd);
    chk("R6 flush valid", fv, 1);
    chk("R6 flush addr", fa, 8'h10);
    chk("R6 flush data", fd, 16'h3333);
    run_req(0, 8'h10, 0, 16'h0);
    chk("R6 still readable locally", n_cmd, 0);
    run_req(1, 8'h10, 16'h4444, 16'h0);
    chk("R6 no longer modified", cmds[0], C_RDX);
  endtask

  task automatic t_snoop_rdx_mod;
    bit fv; logic [AW-1:0] fa; logic [DW-1:0] fd;
    snoop(C_RDX, 8'h10, OTHER, fv, fa, fd);
    chk("R8 flush valid", fv, 1);
    chk("R8 flush data", fd, 16'h4444);
    run_req(0, 8'h10, 0, 16'h5A5A);
    chk("R8 line invalid", cmds[0], C_RD);
    chk("R8 read count", n_cmd, 1);
  endtask

  task automatic t_snoop_shared;
    bit fv; logic [AW-1:0] fa; logic [DW-1:0] fd;
    snoop(C_RD, 8'h10, OTHER, fv, fa, fd);
    chk("R7 read on shared no flush", fv, 0);
    run_req(0, 8'h10, 0, 16'h0);
    chk("R7 shared kept", n_cmd, 0);
    snoop(C_RDX, 8'h10, OTHER, fv, fa, fd);
    chk("R7 readx on shared no flush", fv, 0);
    run_req(0, 8'h10, 0, 16'h0101);
    chk("R7 shared invalidated", n_cmd, 1);
  endtask

  task automatic t_ignore;
    bit fv; logic [AW-1:0] fa; logic [DW-1:0] fd;
    snoop(C_RDX, 8'h21, ME, fv, fa, fd);
    chk("R9 own snoop no flush", fv, 0);
    snoop(C_RDX, 8'h25, OTHER, fv, fa, fd);
    chk("R9 tag mismatch no flush", fv, 0);
    run_req(1, 8'h21, 16'h2223, 16'h0);
    chk("R9 line still modified", n_cmd, 0);
  endtask

  task automatic t_writeback;
    run_req(0, 8'h25, 0, 16'h7777);
    chk("R11 two commands", n_cmd, 2);
    chk("R11 first is write-back", cmds[0], C_WB);
    chk("R11 write-back addr", caddr[0], 8'h21);
    chk("R11 flush count", n_fl, 1);
    chk("R11 flush addr", last_fl_addr, 8'h21);
    chk("R11 flush data", last_fl_data, 16'h2223);
    chk("R11 then read", cmds[1], C_RD);
    chk("R11 read addr", caddr[1], 8'h25);
    chk("R11 data", last_rdata, 16'h7777);
  endtask

  task automatic t_pending_snoop;
    run_req(1, 8'h32, 16'h5555, 16'h0);
    @(negedge clk);
    pr_valid = 1'b1; pr_write = 1'b0; pr_addr = 8'h36;
    @(negedge clk);
    pr_valid = 1'b0;
    chk("R10 pending wants write-back", bq_cmd, C_WB);
    sn_valid = 1'b1; sn_cmd = C_RDX; sn_addr = 8'h32; sn_src = OTHER;
    @(negedge clk);
    sn_valid = 1'b0;
    chk("R10 snoop flushed first", fl_valid, 1);
    chk("R10 flushed word", fl_data, 16'h5555);
    chk("R10 command re-evaluated", bq_cmd, C_RD);
    chk("R10 re-evaluated addr", bq_addr, 8'h36);
    bq_gnt = 1'b1;
    @(negedge clk);
    bq_gnt = 1'b0; bus_ready = 1'b1; bus_rdata = 16'h6666;
    @(negedge clk);
    bus_ready = 1'b0;
    chk("R10 done", pr_done, 1);
    chk("R10 data", pr_rdata, 16'h6666);
  endtask

  initial begin
    rst_n = 1'b0; pr_valid = 0; pr_write = 0; pr_addr = '0; pr_wdata = '0;
    bq_gnt = 0; bus_ready = 0; bus_rdata = '0;
    sn_valid = 0; sn_cmd = '0; sn_addr = '0; sn_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_write_upgrade();
    t_write_hit();
    t_snoop_rd_mod();
    t_snoop_rdx_mod();
    t_snoop_shared();
    t_ignore();
    t_writeback();
    t_pending_snoop();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule